// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single asynchronous serial line into bytes. The line first passes a three-sample glitch filter. A falling edge seen while idle starts a frame, and the bit timing is synchronised to that edge. Every bit, the start bit included, is sampled at its centre. The host selects the frame shape at run time:

- data length: 5, 6, 7 or 8 bits;
- parity: none, odd or even;
- stop length: one, one and a half, or two bit times.

The timing input is a half-bit divisor. One half-bit lasts `half_div_i + 1` clocks.

The host reads the received byte from `data_o` and pulses `rd_clr_i` when it does so. That pulse clears the received flag and all four error flags. A soft reset returns the frame engine to idle; the host raises it whenever it rewrites the format or the rate.

In local handshake mode the receiver drives the active-low request and ready lines itself. When local handshake mode is off, those two outputs simply follow values set by the host. An optional hold mode makes the receiver ignore new frames until the pending byte has been read.

Top module: `serial_rx_unit`

## Requirements
- R1: The line input is filtered by three successive samples. A low pulse shorter than three clocks starts no frame and sets no flag.
- R2: After the filtered falling edge of a start bit, each bit is sampled at its centre. One bit period is `2*(half_div_i+1)` clocks.
- R3: `len_i` selects the data length: 00=5, 01=6, 10=7, 11=8 bits. Bits arrive LSB first and are right-justified in `data_o`, with the unused upper bits zero.
- R4: `par_i` selects parity: 01=odd, 10=even, 00 and 11=none. A parity bit that breaks the selected rule sets `parity_err_o`. The byte is still delivered and `rcvd_o` still set.
- R5: If the start bit is high again at its centre sample, `start_err_o` is set, the frame is abandoned and `rcvd_o` stays low.
- R6: `stop_i` selects the stop length: 00 and 11=one bit, 01=one and a half, 10=two. A low first stop sample sets `frame_err_o`. In two-stop mode a low second stop sample also sets it.
- R7: `rcvd_o` sets when a frame completes. A one-clock `rd_clr_i` pulse clears `rcvd_o`, `start_err_o`, `parity_err_o`, `frame_err_o` and `overrun_err_o`.
- R8: A frame that completes while `rcvd_o` is still set sets `overrun_err_o`. The new byte still replaces `data_o`.
- R9: With `local_hs_i`=1, `rts_no` and `dtr_no` are low after reset. They go high when a start bit is detected while `rcvd_o` is set, and return low on `rd_clr_i`.
- R10: With `local_hs_i`=0, `rts_no` and `dtr_no` follow `rts_sw_i` and `dtr_sw_i`.
- R11: With `hold_unread_i`=1, start bits arriving while `rcvd_o` is set are ignored. `data_o` keeps the unread byte and no overrun is flagged.
- R12: `soft_rst_i` returns the frame engine to idle at once. A frame in progress is dropped and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Return the frame engine to idle |
| half_div_i | input | DIV_W | Half-bit divisor; half-bit = value+1 clocks |
| len_i | input | 2 | Data length select |
| par_i | input | 2 | Parity select |
| stop_i | input | 2 | Stop length select |
| local_hs_i | input | 1 | 1 = receiver drives the handshake lines |
| hold_unread_i | input | 1 | 1 = ignore new frames while a byte is unread |
| rd_clr_i | input | 1 | Host read pulse; clears the flags |
| rts_sw_i | input | 1 | Host value for rts_no when local handshake mode is off |
| dtr_sw_i | input | 1 | Host value for dtr_no when local handshake mode is off |
| rxd_i | input | 1 | Serial line |
| data_o | output | 8 | Received byte, right-justified |
| rcvd_o | output | 1 | Byte received and unread |
| start_err_o | output | 1 | Start bit not low at its centre |
| parity_err_o | output | 1 | Parity mismatch |
| frame_err_o | output | 1 | Stop bit sampled low |
| overrun_err_o | output | 1 | Byte completed over an unread one |
| rts_no | output | 1 | Request line, active low |
| dtr_no | output | 1 | Ready line, active low |

## Verification
The bench sweeps every combination of length, parity and stop codes at two divisors, with two data patterns each. A wrong centre point or a wrong bit count would show up as shifted or merged data bits. Parity with the wrong polarity would flag every good frame.

Targeted frames cover the remaining corners:
- a short low pulse that must be swallowed by the filter;
- a false start that must be rejected at mid-bit;
- a low second stop bit, which is an error in two-stop mode but only a false start in one-stop mode;
- back-to-back frames with and without the hold mode, where a design that mishandled the unread state would lose the overrun or the handshake rise;
- a soft reset in mid-frame, which must leave no flag behind.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int MAX_BITS = 8;
  localparam int IDX_W    = $clog2(MAX_BITS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  localparam logic [1:0] PAR_ODD      = 2'b01;
  localparam logic [1:0] PAR_EVEN     = 2'b10;
  localparam logic [1:0] STOP_ONEHALF = 2'b01;
  localparam logic [1:0] STOP_TWO     = 2'b10;
endpackage

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic              q_q;

  // output moves only when every stage agrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
      q_q  <= 1'b1;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], d_i};
      if (&sh_q)       q_q <= 1'b1;
      else if (~|sh_q) q_q <= 1'b0;
    end
  end

  assign q_o = q_q;

  p_filter_agree_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q != $past(q_q)) |-> ($past(&sh_q) || $past(~|sh_q)));
endmodule

// File: rtl/rx_half_timer.sv
module rx_half_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= half_div_i;
    else if (cnt_q == '0)     cnt_q <= half_div_i;
    else                      cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0) && !restart_i;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [DIV_W-1:0]    half_div_i,
  input  logic [1:0]          len_i,
  input  logic [1:0]          par_i,
  input  logic [1:0]          stop_i,
  input  logic                lock_i,
  input  logic                line_i,
  output logic                start_det_o,
  output logic                start_err_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                par_err_o,
  output logic                frm_err_o
);
  rx_state_e            state_q;
  logic                 phase_q, line_q, done_q, serr_q, perr_q, ferr_q;
  logic [IDX_W-1:0]     bit_idx_q;
  logic [MAX_BITS-1:0]  data_q;
  logic                 half_tick, start_go, par_en;
  logic [IDX_W-1:0]     last_idx;

  assign start_go = (state_q == ST_IDLE) && line_q && !line_i && !lock_i && !soft_rst_i;
  assign par_en   = (par_i == PAR_ODD) || (par_i == PAR_EVEN);
  assign last_idx = IDX_W'(MAX_BITS - 4) + IDX_W'(len_i);

  rx_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (start_go || soft_rst_i),
    .half_div_i (half_div_i),
    .tick_o     (half_tick)
  );

  // phase=1 marks the half tick that lands on a bit centre
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= 1'b0;
      line_q    <= 1'b1;
      bit_idx_q <= '0;
      data_q    <= '0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      done_q    <= 1'b0;
      serr_q    <= 1'b0;
    end else begin
      line_q <= line_i;
      done_q <= 1'b0;
      serr_q <= 1'b0;
      if (soft_rst_i) begin
        state_q <= ST_IDLE;
        phase_q <= 1'b0;
      end else if (start_go) begin
        state_q   <= ST_START;
        phase_q   <= 1'b1;
        data_q    <= '0;
        perr_q    <= 1'b0;
        ferr_q    <= 1'b0;
        bit_idx_q <= '0;
      end else if (state_q != ST_IDLE && half_tick) begin
        phase_q <= ~phase_q;
        if (phase_q) begin
          unique case (state_q)
            ST_START: begin
              if (line_i) begin
                serr_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_DATA;
              end
            end
            ST_DATA: begin
              data_q[bit_idx_q] <= line_i;
              bit_idx_q         <= bit_idx_q + 1'b1;
              if (bit_idx_q == last_idx) state_q <= par_en ? ST_PAR : ST_STOP1;
            end
            ST_PAR: begin
              perr_q  <= ((^data_q) ^ line_i) != (par_i == PAR_ODD);
              state_q <= ST_STOP1;
            end
            ST_STOP1: begin
              ferr_q <= ~line_i;
              if (stop_i == STOP_TWO) begin
                state_q <= ST_STOP2;
              end else if (stop_i == STOP_ONEHALF) begin
                state_q <= ST_STOP2;
                phase_q <= 1'b1;  // only one more half-bit
              end else begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
            ST_STOP2: begin
              if (stop_i == STOP_TWO) ferr_q <= ferr_q | ~line_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign start_det_o = start_go;
  assign start_err_o = serr_q;
  assign done_o      = done_q;
  assign data_o      = data_q;
  assign par_err_o   = perr_q;
  assign frm_err_o   = ferr_q;

  p_soft_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (state_q == ST_IDLE));
  p_lock_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && lock_i) |=> (state_q == ST_IDLE));
  p_done_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q == ST_STOP1 || state_q == ST_STOP2));
  p_start_err_from_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_q |-> $past(state_q == ST_START));
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int FILT_ST = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [DIV_W-1:0]    half_div_i,
  input  logic [1:0]          len_i,
  input  logic [1:0]          par_i,
  input  logic [1:0]          stop_i,
  input  logic                local_hs_i,
  input  logic                hold_unread_i,
  input  logic                rd_clr_i,
  input  logic                rts_sw_i,
  input  logic                dtr_sw_i,
  input  logic                rxd_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                rcvd_o,
  output logic                start_err_o,
  output logic                parity_err_o,
  output logic                frame_err_o,
  output logic                overrun_err_o,
  output logic                rts_no,
  output logic                dtr_no
);
  logic                line_f, start_det, c_serr, c_done, c_perr, c_ferr;
  logic [MAX_BITS-1:0] c_data, data_q;
  logic                rcvd_q, serr_q, perr_q, ferr_q, ovr_q, busy_q;

  rx_glitch_filter #(.STAGES(FILT_ST)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (line_f)
  );

  rx_frame_fsm #(.DIV_W(DIV_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .half_div_i  (half_div_i),
    .len_i       (len_i),
    .par_i       (par_i),
    .stop_i      (stop_i),
    .lock_i      (hold_unread_i && rcvd_q),
    .line_i      (line_f),
    .start_det_o (start_det),
    .start_err_o (c_serr),
    .done_o      (c_done),
    .data_o      (c_data),
    .par_err_o   (c_perr),
    .frm_err_o   (c_ferr)
  );

  // clear first, then let a same-cycle event set again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rcvd_q <= 1'b0;
      serr_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (rd_clr_i) begin
        rcvd_q <= 1'b0;
        serr_q <= 1'b0;
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
        ovr_q  <= 1'b0;
        busy_q <= 1'b0;
      end
      if (c_serr) serr_q <= 1'b1;
      if (c_done) begin
        data_q <= c_data;
        rcvd_q <= 1'b1;
        perr_q <= (perr_q && !rd_clr_i) || c_perr;
        ferr_q <= (ferr_q && !rd_clr_i) || c_ferr;
        ovr_q  <= (ovr_q && !rd_clr_i) || (rcvd_q && !rd_clr_i);
      end
      if (start_det && rcvd_q && !rd_clr_i) busy_q <= 1'b1;
    end
  end

  assign data_o        = data_q;
  assign rcvd_o        = rcvd_q;
  assign start_err_o   = serr_q;
  assign parity_err_o  = perr_q;
  assign frame_err_o   = ferr_q;
  assign overrun_err_o = ovr_q;
  assign rts_no        = local_hs_i ? busy_q : rts_sw_i;
  assign dtr_no        = local_hs_i ? busy_q : dtr_sw_i;

  p_ovr_needs_unread_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_err_o) |-> $past(rcvd_o));
  p_clear_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !c_done && !c_serr) |=> !(rcvd_o || start_err_o || parity_err_o
                                            || frame_err_o || overrun_err_o));
  p_busy_needs_unread_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(rcvd_o));
  p_hold_keeps_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_unread_i && rcvd_o && $past(hold_unread_i && rcvd_o)) |-> $stable(data_o));
endmodule

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic [DW-1:0] half_div = 8'd3;
  logic [1:0]    len = 2'b11, par = 2'b00, stp = 2'b00;
  logic          local_hs = 1'b1, hold = 1'b0, rd_clr = 1'b0;
  logic          rts_sw = 1'b0, dtr_sw = 1'b0, rxd = 1'b1;
  logic [7:0]    data;
  logic          rcvd, serr, perr, ferr, ovr, rts_n, dtr_n;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_rx_unit #(.DIV_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .half_div_i(half_div),
    .len_i(len), .par_i(par), .stop_i(stp), .local_hs_i(local_hs),
    .hold_unread_i(hold), .rd_clr_i(rd_clr), .rts_sw_i(rts_sw), .dtr_sw_i(dtr_sw),
    .rxd_i(rxd), .data_o(data), .rcvd_o(rcvd), .start_err_o(serr),
    .parity_err_o(perr), .frame_err_o(ferr), .overrun_err_o(ovr),
    .rts_no(rts_n), .dtr_no(dtr_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_cyc();
    return 2 * (int'(half_div) + 1);
  endfunction

  task automatic drive(logic v, int cyc);
    rxd = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic idle_bits(int n);
    drive(1'b1, n * bit_cyc());
  endtask

  task automatic read_clear();
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
  endtask

  // one frame under the current format; optional broken parity / stop bits
  task automatic send(logic [7:0] d, bit bad_par, bit bad_stop1, bit bad_stop2);
    int   nb = 5 + int'(len);
    logic [7:0] dm = d & 8'((1 << nb) - 1);
    drive(1'b0, bit_cyc());
    for (int i = 0; i < nb; i++) drive(dm[i], bit_cyc());
    if (par == 2'b01) drive(~(^dm) ^ bad_par, bit_cyc());
    if (par == 2'b10) drive((^dm) ^ bad_par, bit_cyc());
    drive(~bad_stop1, bit_cyc());
    if (stp == 2'b10) drive(~bad_stop2, bit_cyc());
    if (stp == 2'b01) drive(1'b1, bit_cyc() / 2);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    check("R7 reset rcvd", rcvd, 0);
    check("R7 reset flags", {serr, perr, ferr, ovr}, 0);
    check("R3 reset data", data, 0);
    check("R9 reset rts/dtr low", {rts_n, dtr_n}, 0);

    // R2/R3/R4/R6 sweep of every format code at two divisors
    for (int dv = 0; dv < 2; dv++) begin
      half_div = (dv == 0) ? 8'd3 : 8'd10;
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 4; p++)
          for (int s = 0; s < 4; s++)
            for (int k = 0; k < 2; k++) begin
              logic [7:0] d = (k == 0) ? 8'hA5 : 8'h3C ^ 8'(l * 37 + p * 11 + s);
              len = 2'(l); par = 2'(p); stp = 2'(s);
              send(d, 0, 0, 0);
              idle_bits(2);
              check("R2 R3 sweep data", data, d & 8'((1 << (5 + l)) - 1));
              check("R7 sweep rcvd", rcvd, 1);
              check("R4 R6 sweep no error", {serr, perr, ferr, ovr}, 0);
              read_clear();
              check("R7 sweep cleared", rcvd, 0);
            end
    end

    // R4 bad parity, both polarities
    half_div = 8'd5; len = 2'b10; stp = 2'b00;
    for (int p = 1; p < 3; p++) begin
      par = 2'(p);
      send(8'h5B, 1, 0, 0);
      idle_bits(2);
      check("R4 parity error", perr, 1);
      check("R4 data kept", {rcvd, data}, {1'b1, 8'h5B});
      read_clear();
      check("R7 clear parity", {rcvd, perr}, 0);
    end

    // R6 low first stop bit
    par = 2'b00; stp = 2'b00; len = 2'b11;
    send(8'hC3, 0, 1, 0);
    idle_bits(2);
    check("R6 stop1 low", {rcvd, ferr, data}, {2'b11, 8'hC3});
    read_clear();
    check("R7 clear framing", ferr, 0);

    // R6 low second stop bit in two-stop mode
    stp = 2'b10;
    send(8'h81, 0, 0, 1);
    idle_bits(2);
    check("R6 stop2 low two-stop", {rcvd, ferr}, 2'b11);
    read_clear();

    // R5 R6 same slot as a short low in one-stop mode: false start, no framing error
    half_div = 8'd7; stp = 2'b00;
    send(8'h42, 0, 0, 0);
    drive(1'b0, 5);
    idle_bits(3);
    check("R6 one-stop no framing", ferr, 0);
    check("R5 false start flagged", serr, 1);
    read_clear();
    check("R7 clear start err", {rcvd, serr}, 0);

    // R5 isolated short low pulse: rejected at mid-bit
    drive(1'b0, 5);
    idle_bits(3);
    check("R5 start error", {serr, rcvd}, 2'b10);
    read_clear();

    // R1 glitch of two clocks is swallowed
    drive(1'b0, 2);
    idle_bits(3);
    check("R1 glitch ignored", {serr, rcvd, ferr}, 0);

    // R8 R9 overrun with local handshake
    half_div = 8'd3; hold = 1'b0; local_hs = 1'b1;
    send(8'h11, 0, 0, 0);
    idle_bits(1);
    check("R9 low while ready", {rts_n, dtr_n}, 0);
    send(8'h22, 0, 0, 0);
    idle_bits(2);
    check("R8 overrun set", {ovr, rcvd}, 2'b11);
    check("R8 new data", data, 8'h22);
    check("R9 raised on unread start", {rts_n, dtr_n}, 2'b11);
    read_clear();
    check("R9 lowered on read", {rts_n, dtr_n}, 0);
    check("R7 clear overrun", ovr, 0);

    // R11 hold mode ignores a second frame
    hold = 1'b1;
    send(8'h33, 0, 0, 0);
    idle_bits(1);
    send(8'h44, 0, 0, 0);
    idle_bits(2);
    check("R11 first byte kept", data, 8'h33);
    check("R11 no overrun", {ovr, rcvd}, 2'b01);
    check("R11 handshake stays low", rts_n, 0);
    read_clear();
    hold = 1'b0;

    // R10 host-driven lines
    local_hs = 1'b0;
    rts_sw = 1'b1; dtr_sw = 1'b0;
    @(negedge clk);
    check("R10 follow host 10", {rts_n, dtr_n}, 2'b10);
    rts_sw = 1'b0; dtr_sw = 1'b1;
    @(negedge clk);
    check("R10 follow host 01", {rts_n, dtr_n}, 2'b01);
    local_hs = 1'b1;

    // R12 soft reset mid-frame
    len = 2'b11; par = 2'b00; stp = 2'b00;
    drive(1'b0, 3 * bit_cyc());
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
    idle_bits(15);
    check("R12 frame dropped", {rcvd, serr, ferr, perr}, 0);
    send(8'h96, 0, 0, 0);
    idle_bits(2);
    check("R12 receives after soft reset", {rcvd, data}, {1'b1, 8'h96});

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule